// File: doc/BRIEF.md
# Serial Program Image Loader

This block takes a program image arriving on an asynchronous serial line and writes it into a program memory that is 24 bits wide. A receiver running on a 16x oversampling enable recovers bytes in 8N1 framing. A loader state machine groups every three bytes into one 24-bit field, least significant byte first. The first field is the number of words to load. The second is the memory address where loading begins. Each later field is one program word.

Each word leaves through a valid/ready memory write port. A word goes to the next consecutive address, starting at the load address. After the last word is accepted, a one-cycle done pulse is raised. The load address stays on a separate output as the address to start execution from.

Every byte that arrives with good framing is sent back on the serial output. The echo path uses a one-entry holding buffer. If a byte completes while that buffer is still occupied, an overflow pulse is raised. The baud-rate enable comes from outside the block.

Back-pressure rules for the write port:
- `mem_wr_valid` stays high, with address and data unchanged, until `mem_wr_ready` is seen high at a clock edge.
- The memory side must accept a word within one serial byte time. A byte that completes while a write is still waiting is dropped.

Top module: `uart_prog_loader`

## Requirements
- R1: The first three good bytes after reset, or after a done pulse, form the word count. Byte 0 is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16.
- R2: The next three bytes form the load address in the same byte order. After the load completes, `exec_addr` equals that address.
- R3: Each following group of three bytes (LSB first) is written as one word. Word k of the image goes to address load_address + k.
- R4: While `mem_wr_valid` is high and `mem_wr_ready` is low, valid stays high and `mem_wr_addr` and `mem_wr_data` hold their values.
- R5: `load_done` pulses for one cycle, in the cycle after the final word is accepted. The block then expects a new count field.
- R6: A count of zero produces `load_done` right after the address field, with no memory write.
- R7: The receiver decodes 8N1 frames, data LSB first. Each bit is sampled once, near its middle, counted in ticks of `tick_16x`.
- R8: If the start bit is no longer low at half a bit time, it is rejected. No byte results, nothing is echoed and the loader is unaffected.
- R9: A frame whose stop bit is low raises `frame_err` for one cycle. Its byte is neither echoed nor used by the loader. The receiver then waits for the line to return high.
- R10: Every good byte is sent back on `txd` with one start bit (0), 8 data bits LSB first, and TX_STOP_BITS stop bits (1). `txd` is high when idle.
- R11: A byte that completes while the one-entry echo buffer is already full raises `echo_ovf` for one cycle, and that byte is not echoed.
- R12: After reset, `txd` is high, and `mem_wr_valid`, `load_done`, `frame_err` and `echo_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Enable pulse at 16 times the baud rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial echo line |
| mem_wr_valid | output | 1 | A write word is offered |
| mem_wr_ready | input | 1 | Memory accepts the offered word |
| mem_wr_addr | output | 24 | Write address |
| mem_wr_data | output | 24 | Write data |
| load_done | output | 1 | One-cycle pulse when the image is complete |
| exec_addr | output | 24 | Address to start execution from (the load address) |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |
| echo_ovf | output | 1 | One-cycle pulse when an echo byte is lost |

## Verification
The bench builds the block with OVERSAMPLE=16 and TX_STOP_BITS=2. The echo frame is therefore one bit longer than a received frame, so a back-to-back burst of bytes slowly fills the echo buffer until it overflows. Paced traffic never does. `tick_16x` pulses every second clock, giving a 32-clock bit. This keeps whole images, including a stalled memory port, glitch rejection and a framing error, within a short run.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT} rx_state_e;
  typedef enum logic [1:0] {LD_COUNT, LD_ADDR, LD_DATA, LD_WRITE} ld_state_e;
endpackage

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import loader_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       frame_err
);
  localparam int CW = $clog2(OS);
  localparam logic [CW-1:0] MID  = CW'(OS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  logic [1:0]    sync;
  logic          rx_s;
  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;

  assign rx_s      = sync[1];
  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; st <= RX_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      byte_valid <= 1'b0; frame_err <= 1'b0;
    end else begin
      sync       <= {sync[0], rxd};
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      case (st)
        RX_IDLE: if (tick && !rx_s) begin st <= RX_START; cnt <= '0; end
        RX_START: if (tick) begin
          if (cnt == MID) begin
            if (!rx_s) begin st <= RX_DATA; cnt <= '0; bitn <= '0; end
            else st <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == 3'd7) st <= RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (rx_s) begin byte_valid <= 1'b1; st <= RX_IDLE; end
            else begin frame_err <= 1'b1; st <= RX_WAIT; end
          end else cnt <= cnt + 1'b1;
        end
        default: if (rx_s) st <= RX_IDLE;
      endcase
    end
  end

  // R9: a frame is either good or flagged, never both
  a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && frame_err));
  // R9: after a framing error the receiver waits for an idle line
  a_r9_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> st == RX_WAIT);
endmodule

// File: rtl/uart_tx_echo.sv
module uart_tx_echo #(
  parameter int OS        = 16,
  parameter int STOP_BITS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       txd,
  output logic       ovf
);
  localparam int NB = 9 + STOP_BITS;
  localparam int CW = $clog2(OS);
  localparam int BW = $clog2(NB + 1);

  logic          hold_full;
  logic [7:0]    hold_data;
  logic          busy;
  logic [NB-1:0] sh;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic          start;

  assign start = !busy && hold_full;
  assign txd   = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0; hold_data <= '0; busy <= 1'b0; sh <= '1;
      cnt <= '0; left <= '0; ovf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        sh   <= {{STOP_BITS{1'b1}}, hold_data, 1'b0};
        cnt  <= '0;
        left <= BW'(NB);
      end else if (busy && tick) begin
        if (cnt == CW'(OS - 1)) begin
          cnt  <= '0;
          sh   <= {1'b1, sh[NB-1:1]};
          left <= left - 1'b1;
          if (left == BW'(1)) busy <= 1'b0;
        end else cnt <= cnt + 1'b1;
      end
      if (in_valid) begin
        if (hold_full && !start) ovf <= 1'b1;
        else begin hold_data <= in_data; hold_full <= 1'b1; end
      end else if (start) hold_full <= 1'b0;
    end
  end

  // R11: overflow only reported while the buffer still holds a byte
  a_r11_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> hold_full);
  // R10: every echo frame begins with a low start bit
  a_r10_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/loader_fsm.sv
module loader_fsm
  import loader_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic [AW-1:0] start_addr
);
  localparam int NB  = DW / 8;
  localparam int BCW = (NB > 1) ? $clog2(NB) : 1;

  ld_state_e      st;
  logic [DW-1:0]  acc;
  logic [DW-1:0]  field;
  logic [BCW-1:0] bcnt;
  logic           last;
  logic [DW-1:0]  remaining;
  logic [AW-1:0]  cur;

  assign field    = {in_byte, acc[DW-1:8]};
  assign last     = (bcnt == BCW'(NB - 1));
  assign wr_valid = (st == LD_WRITE);
  assign wr_addr  = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LD_COUNT; acc <= '0; bcnt <= '0; remaining <= '0;
      cur <= '0; start_addr <= '0; wr_data <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == LD_WRITE) begin
        if (wr_ready) begin
          cur       <= cur + 1'b1;
          remaining <= remaining - 1'b1;
          if (remaining == DW'(1)) begin done <= 1'b1; st <= LD_COUNT; end
          else st <= LD_DATA;
        end
      end else if (in_valid) begin
        acc  <= field;
        bcnt <= last ? '0 : bcnt + 1'b1;
        if (last) begin
          case (st)
            LD_COUNT: begin remaining <= field; st <= LD_ADDR; end
            LD_ADDR: begin
              start_addr <= field[AW-1:0];
              cur        <= field[AW-1:0];
              if (remaining == '0) begin done <= 1'b1; st <= LD_COUNT; end
              else st <= LD_DATA;
            end
            default: begin wr_data <= field; st <= LD_WRITE; end
          endcase
        end
      end
    end
  end

  // R4: an offered word is held steady until accepted
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R3: an accepted non-final word advances the address by one
  a_r3_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && remaining != DW'(1) |=> cur == $past(cur) + 1'b1);
  // R5: done returns the loader to count collection
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st == LD_COUNT && !wr_valid);
endmodule

// File: rtl/uart_prog_loader.sv
module uart_prog_loader #(
  parameter int OVERSAMPLE   = 16,
  parameter int TX_STOP_BITS = 1,
  parameter int DW           = 24,
  parameter int AW           = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_16x,
  input  logic          rxd,
  output logic          txd,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          load_done,
  output logic [AW-1:0] exec_addr,
  output logic          frame_err,
  output logic          echo_ovf
);
  logic       rx_valid;
  logic [7:0] rx_byte;

  uart_rx_os #(.OS(OVERSAMPLE)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .rxd(rxd),
    .byte_valid(rx_valid), .byte_data(rx_byte), .frame_err(frame_err));

  uart_tx_echo #(.OS(OVERSAMPLE), .STOP_BITS(TX_STOP_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .in_valid(rx_valid),
    .in_data(rx_byte), .txd(txd), .ovf(echo_ovf));

  loader_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_byte(rx_byte),
    .wr_valid(mem_wr_valid), .wr_ready(mem_wr_ready), .wr_addr(mem_wr_addr),
    .wr_data(mem_wr_data), .done(load_done), .start_addr(exec_addr));
endmodule

// File: tb/tb_uart_prog_loader.sv
module tb_uart_prog_loader;
  localparam int BIT = 32;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1, mem_wr_ready = 1'b1;
  logic txd, mem_wr_valid, load_done, frame_err, echo_ovf;
  logic [23:0] mem_wr_addr, mem_wr_data, exec_addr;

  int checks = 0, errors = 0, fe_cnt = 0, ovf_cnt = 0;
  bit stall_en = 0, echo_chk = 1, finished = 0;
  logic [31:0] cyc = 0;
  logic [7:0]  echo_q[$];
  logic [47:0] mem_q[$];
  logic [23:0] done_q[$];

  uart_prog_loader #(.OVERSAMPLE(16), .TX_STOP_BITS(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick), .rxd(rxd), .txd(txd),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .load_done(load_done),
    .exec_addr(exec_addr), .frame_err(frame_err), .echo_ovf(echo_ovf));

  always #10 clk = ~clk;
  always @(negedge clk) tick = ~tick;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_wr_ready <= !stall_en || (cyc[1:0] == 2'b11);
  end

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitors: memory writes, done, pulses, write hold
  logic        pend = 0;
  logic [47:0] pend_v = 0;
  always @(negedge clk) if (rst_n) begin
    if (pend) check(mem_wr_valid && {mem_wr_addr, mem_wr_data} == pend_v,
                    "R4 hold", {mem_wr_addr, mem_wr_data}, pend_v);
    pend   = mem_wr_valid && !mem_wr_ready;
    pend_v = {mem_wr_addr, mem_wr_data};
    if (mem_wr_valid && mem_wr_ready) begin
      if (mem_q.size() == 0) check(0, "R3 unexpected write", {mem_wr_addr, mem_wr_data}, 0);
      else begin
        logic [47:0] e;
        e = mem_q.pop_front();
        check({mem_wr_addr, mem_wr_data} == e, "R3 R7 write", {mem_wr_addr, mem_wr_data}, e);
      end
    end
    if (load_done) begin
      if (done_q.size() == 0) check(0, "R5 unexpected done", exec_addr, 0);
      else begin
        logic [23:0] d;
        d = done_q.pop_front();
        check(exec_addr == d, "R2 R5 exec_addr", exec_addr, d);
        check(mem_q.size() == 0, "R5 done after last write", mem_q.size(), 0);
      end
    end
    if (frame_err) fe_cnt++;
    if (echo_ovf) ovf_cnt++;
  end

  // Echo monitor: decodes txd and compares with expected bytes
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (BIT + BIT/2 - 1) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          b[i] = txd;
          if (i < 7) repeat (BIT) @(negedge clk);
        end
        repeat (BIT) @(negedge clk);
        if (echo_chk) begin
          check(txd == 1'b1, "R10 stop bit", txd, 1);
          if (echo_q.size() == 0) check(0, "R10 unexpected echo", b, 0);
          else begin
            logic [7:0] e;
            e = echo_q.pop_front();
            check(b == e, "R10 echo byte", b, e);
          end
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit good, input int gap);
    if (good && echo_chk) echo_q.push_back(b);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = good;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (gap * BIT) @(negedge clk);
  endtask

  task automatic send_field(input logic [23:0] v, input int gap);
    for (int i = 0; i < 3; i++) send_byte(v[8*i +: 8], 1'b1, gap);
  endtask

  task automatic send_load(input logic [23:0] n, input logic [23:0] addr,
                           input logic [23:0] w0, input int gap);
    for (int k = 0; k < int'(n); k++)
      mem_q.push_back({addr + 24'(k), w0 ^ (24'(k) * 24'h111111)});
    done_q.push_back(addr);
    send_field(n, gap);
    send_field(addr, gap);
    for (int k = 0; k < int'(n); k++) send_field(w0 ^ (24'(k) * 24'h111111), gap);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R12: reset state
    check(txd == 1'b1, "R12 txd idle", txd, 1);
    check(!mem_wr_valid && !load_done, "R12 no valid/done", {mem_wr_valid, load_done}, 0);
    check(!frame_err && !echo_ovf, "R12 no pulses", {frame_err, echo_ovf}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R1 R3 R4 R7: three words with a stalling memory port
    stall_en = 1;
    send_load(24'd3, 24'h001234, 24'hABCDEF, 1);
    repeat (12 * BIT) @(negedge clk);
    stall_en = 0;
    check(done_q.size() == 0, "R5 done seen", done_q.size(), 0);

    // R6: zero-count image
    send_load(24'd0, 24'h00FF00, 24'h0, 1);
    repeat (12 * BIT) @(negedge clk);
    check(done_q.size() == 0, "R6 zero count done", done_q.size(), 0);

    // R8: short start glitch, then a load must still parse
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BIT) @(negedge clk);
    send_load(24'd1, 24'h000010, 24'h00A5C3, 1);
    repeat (12 * BIT) @(negedge clk);
    check(done_q.size() == 0 && mem_q.size() == 0, "R8 glitch ignored", done_q.size(), 0);

    // R9: low stop bit, byte discarded, then a load must still parse
    send_byte(8'h55, 1'b0, 0);
    rxd = 1'b0;
    repeat (2 * BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    check(fe_cnt == 1, "R9 frame_err count", fe_cnt, 1);
    send_load(24'd1, 24'h0000F0, 24'h7E8100, 1);
    repeat (12 * BIT) @(negedge clk);
    check(done_q.size() == 0 && mem_q.size() == 0, "R9 byte not used", mem_q.size(), 0);
    check(echo_q.size() == 0, "R10 R9 echo queue drained", echo_q.size(), 0);

    // R11: back-to-back burst outpaces the longer echo frame
    check(ovf_cnt == 0, "R11 no overflow when paced", ovf_cnt, 0);
    echo_chk = 0;
    send_load(24'd3, 24'h800000, 24'h13579B, 0);
    repeat (40 * BIT) @(negedge clk);
    check(ovf_cnt > 0, "R11 overflow flagged", ovf_cnt, 1);
    check(done_q.size() == 0 && mem_q.size() == 0, "R3 burst load complete", mem_q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule